// File: doc/BRIEF.md
# Bus Node Status and Error-State Register

This block holds the status byte of a serial bus node and the logic that keeps it current. The protocol engine reports three kinds of one-cycle events: a frame received without error, a frame sent and acknowledged by another node, and a detected error together with its type. The transmit and receive error counters are also brought in as plain values. From these inputs the block keeps two error-state flags, two sticky success flags and a last-error-code field.

The bus-off flag also drives an output that tells the transmitter to release the bus line. Software can read the whole byte. It can write the low five bits to clear the success flags or to load the error code. The block raises two request strobes. A status-change request follows successful traffic and changes of the error code. An error request follows entry into the warning or bus-off state. A source enable gates each request, and a global enable gates both.

Top module: `busnode_status_reg`

## Requirements
- R1: The status byte `status_o` has this layout: bit 7 is bus-off, bit 6 is warning, bit 5 always reads 0, bit 4 is receive-OK, bit 3 is transmit-OK, and bits 2:0 are the last error code. Every bit is 0 after reset.
- R2: Bus-off sets one cycle after either counter is at 256 or more. It then stays set, even after the counters fall, until a cycle with `recover_i` high clears it. `recover_i` wins over a set in the same cycle. `tx_float_o` is high exactly while bus-off is set.
- R3: Warning is 1 in the cycle after either counter is at 96 or more. It is 0 in the cycle after both counters are below 96.
- R4: Receive-OK sets one cycle after `rx_ok_i`. There is no acceptance input, so every error-free frame counts. The flag stays set until software clears it.
- R5: Transmit-OK sets one cycle after `tx_ok_i`. The engine pulses this input only for acknowledged frames. The flag stays set until software clears it.
- R6: The error code is loaded from `err_code_i` only by the first `err_i` after a `frame_start_i`, or by an `err_i` in the same cycle as `frame_start_i`. Later errors leave it unchanged until the next frame start. The codes are: 0 none, 1 stuff, 2 form, 3 acknowledgment, 4 bit-1, 5 bit-0, 6 CRC, 7 unused.
- R7: A cycle with `sw_wr_i` high loads bits 4:0 from `sw_wdata_i[4:0]`. Bits 7:5 of the written value have no effect. If a hardware set or capture happens in the same cycle, the hardware value wins.
- R8: `stat_irq_o` pulses for one cycle, in the cycle after a receive-OK event, a transmit-OK event or a captured error code that differs from the stored one. It pulses only when `ctl_sie_i` and `ctl_gie_i` are both high.
- R9: `err_irq_o` pulses for one cycle, in the cycle after warning or bus-off goes from 0 to 1. It pulses only when `ctl_eie_i` and `ctl_gie_i` are both high.
- R10: While `ctl_gie_i` is low, neither request is raised, but the status flags still update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start_i | input | 1 | Start of a frame; re-arms error-code capture |
| rx_ok_i | input | 1 | Frame received without error |
| tx_ok_i | input | 1 | Frame sent and acknowledged |
| err_i | input | 1 | Error detected |
| err_code_i | input | 3 | Type of the detected error |
| tec_i | input | CNT_W | Transmit error counter value |
| rec_i | input | CNT_W | Receive error counter value |
| recover_i | input | 1 | Bus-off recovery completed |
| sw_wr_i | input | 1 | Software write strobe |
| sw_wdata_i | input | 8 | Software write data |
| ctl_gie_i | input | 1 | Global interrupt enable |
| ctl_sie_i | input | 1 | Status-change interrupt enable |
| ctl_eie_i | input | 1 | Error interrupt enable |
| status_o | output | 8 | Status byte |
| tx_float_o | output | 1 | Release the transmit line |
| stat_irq_o | output | 1 | Status-change request pulse |
| err_irq_o | output | 1 | Error request pulse |

## Verification
The bound checker watches the following on every cycle:
- each success strobe sets its flag;
- the counter thresholds move the warning and bus-off flags;
- bus-off holds until recovery;
- a second error in one frame does not disturb the error code;
- each request appears only after its enables were high.

Only the directed scenarios can show the remaining behaviour:
- that a request is a single-cycle pulse;
- that an error capture repeating the stored code raises no request;
- that software writes leave the read-only bits alone while hardware wins a same-cycle conflict;
- that the error-state request fires on entry only.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [2:0] {
        LEC_NONE  = 3'd0,
        LEC_STUFF = 3'd1,
        LEC_FORM  = 3'd2,
        LEC_ACK   = 3'd3,
        LEC_BIT1  = 3'd4,
        LEC_BIT0  = 3'd5,
        LEC_CRC   = 3'd6,
        LEC_SPARE = 3'd7
    } lec_e;

    typedef struct packed {
        logic       busoff;
        logic       warn;
        logic       rx_ok;
        logic       tx_ok;
        logic [2:0] lec;
    } bsr_flags_t;

    typedef struct packed {
        bsr_flags_t flags;
        logic       armed;
        logic       stat_irq;
        logic       err_irq;
    } bsr_state_t;

    localparam int STAT_W  = 8;
    localparam int B_RXOK  = 4;
    localparam int B_TXOK  = 3;

endpackage

// File: rtl/bsr_level_detect.sv
module bsr_level_detect #(
    parameter int NUM_CNT  = 2,
    parameter int CNT_W    = 9,
    parameter int WARN_LIM = 96,
    parameter int OFF_LIM  = 256
) (
    input  logic [NUM_CNT*CNT_W-1:0] cnt_i,
    output logic                     warn_o,
    output logic                     off_o
);
    localparam logic [CNT_W-1:0] WARN_V = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] OFF_V  = CNT_W'(OFF_LIM);

    logic [NUM_CNT-1:0] warn_hit;
    logic [NUM_CNT-1:0] off_hit;

    generate
        for (genvar i = 0; i < NUM_CNT; i++) begin : g_cmp
            assign warn_hit[i] = cnt_i[i*CNT_W +: CNT_W] >= WARN_V;
            assign off_hit[i]  = cnt_i[i*CNT_W +: CNT_W] >= OFF_V;
        end
    endgenerate

    assign warn_o = |warn_hit;
    assign off_o  = |off_hit;

endmodule

// File: rtl/bsr_err_capture.sv
module bsr_err_capture
    import bsr_pkg::*;
(
    input  logic       armed_q,
    input  logic [2:0] lec_q,
    input  logic       frame_start_i,
    input  logic       err_i,
    input  logic [2:0] err_code_i,
    input  logic       sw_ld_i,
    input  logic [2:0] sw_lec_i,
    output logic       armed_d,
    output logic [2:0] lec_d,
    output logic       lec_chg_o
);
    logic armed_eff;
    logic take;

    always_comb begin
        armed_eff = armed_q | frame_start_i;
        take      = err_i & armed_eff;
        armed_d   = armed_eff & ~err_i;
        if (take)
            lec_d = err_code_i;
        else if (sw_ld_i)
            lec_d = sw_lec_i;
        else
            lec_d = lec_q;
        lec_chg_o = take && (err_code_i != lec_q);
    end

endmodule

// File: rtl/bsr_irq_gate.sv
module bsr_irq_gate (
    input  logic gie_i,
    input  logic sie_i,
    input  logic eie_i,
    input  logic rx_evt_i,
    input  logic tx_evt_i,
    input  logic lec_chg_i,
    input  logic warn_rise_i,
    input  logic off_rise_i,
    output logic stat_req_o,
    output logic err_req_o
);
    always_comb begin
        stat_req_o = gie_i & sie_i & (rx_evt_i | tx_evt_i | lec_chg_i);
        err_req_o  = gie_i & eie_i & (warn_rise_i | off_rise_i);
    end

endmodule

// File: rtl/busnode_status_reg.sv
module busnode_status_reg
    import bsr_pkg::*;
#(
    parameter int CNT_W    = 9,
    parameter int WARN_LIM = 96,
    parameter int OFF_LIM  = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start_i,
    input  logic              rx_ok_i,
    input  logic              tx_ok_i,
    input  logic              err_i,
    input  logic [2:0]        err_code_i,
    input  logic [CNT_W-1:0]  tec_i,
    input  logic [CNT_W-1:0]  rec_i,
    input  logic              recover_i,
    input  logic              sw_wr_i,
    input  logic [7:0]        sw_wdata_i,
    input  logic              ctl_gie_i,
    input  logic              ctl_sie_i,
    input  logic              ctl_eie_i,
    output logic [7:0]        status_o,
    output logic              tx_float_o,
    output logic              stat_irq_o,
    output logic              err_irq_o
);
    localparam int NUM_CNT = 2;

    bsr_state_t st_q, st_d;

    logic       warn_lvl, off_lvl;
    logic       armed_d;
    logic [2:0] lec_d;
    logic       lec_chg;
    logic       busoff_d;
    logic       stat_req, err_req;

    bsr_level_detect #(
        .NUM_CNT (NUM_CNT),
        .CNT_W   (CNT_W),
        .WARN_LIM(WARN_LIM),
        .OFF_LIM (OFF_LIM)
    ) u_lvl (
        .cnt_i ({rec_i, tec_i}),
        .warn_o(warn_lvl),
        .off_o (off_lvl)
    );

    bsr_err_capture u_cap (
        .armed_q      (st_q.armed),
        .lec_q        (st_q.flags.lec),
        .frame_start_i(frame_start_i),
        .err_i        (err_i),
        .err_code_i   (err_code_i),
        .sw_ld_i      (sw_wr_i),
        .sw_lec_i     (sw_wdata_i[2:0]),
        .armed_d      (armed_d),
        .lec_d        (lec_d),
        .lec_chg_o    (lec_chg)
    );

    // Recovery overrides a threshold hit in the same cycle.
    assign busoff_d = recover_i ? 1'b0 : (st_q.flags.busoff | off_lvl);

    bsr_irq_gate u_irq (
        .gie_i      (ctl_gie_i),
        .sie_i      (ctl_sie_i),
        .eie_i      (ctl_eie_i),
        .rx_evt_i   (rx_ok_i),
        .tx_evt_i   (tx_ok_i),
        .lec_chg_i  (lec_chg),
        .warn_rise_i(warn_lvl & ~st_q.flags.warn),
        .off_rise_i (busoff_d & ~st_q.flags.busoff),
        .stat_req_o (stat_req),
        .err_req_o  (err_req)
    );

    always_comb begin
        st_d = st_q;
        st_d.flags.busoff = busoff_d;
        st_d.flags.warn   = warn_lvl;
        if (sw_wr_i) begin
            st_d.flags.rx_ok = sw_wdata_i[B_RXOK];
            st_d.flags.tx_ok = sw_wdata_i[B_TXOK];
        end
        if (rx_ok_i)
            st_d.flags.rx_ok = 1'b1;
        if (tx_ok_i)
            st_d.flags.tx_ok = 1'b1;
        st_d.flags.lec = lec_d;
        st_d.armed     = armed_d;
        st_d.stat_irq  = stat_req;
        st_d.err_irq   = err_req;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o   = {st_q.flags.busoff, st_q.flags.warn, 1'b0,
                         st_q.flags.rx_ok, st_q.flags.tx_ok, st_q.flags.lec};
    assign tx_float_o = st_q.flags.busoff;
    assign stat_irq_o = st_q.stat_irq;
    assign err_irq_o  = st_q.err_irq;

endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
    parameter int CNT_W    = 9,
    parameter int WARN_LIM = 96,
    parameter int OFF_LIM  = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start_i,
    input logic             rx_ok_i,
    input logic             tx_ok_i,
    input logic             err_i,
    input logic             recover_i,
    input logic             sw_wr_i,
    input logic [CNT_W-1:0] tec_i,
    input logic [CNT_W-1:0] rec_i,
    input logic             ctl_gie_i,
    input logic             ctl_sie_i,
    input logic             ctl_eie_i,
    input logic [7:0]       status_o,
    input logic             stat_irq_o,
    input logic             err_irq_o
);
    localparam logic [CNT_W-1:0] WV = CNT_W'(WARN_LIM);
    localparam logic [CNT_W-1:0] OV = CNT_W'(OFF_LIM);

    AST_OFF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((tec_i >= OV || rec_i >= OV) && !recover_i) |=> status_o[7]); // R2
    AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7] && !recover_i) |=> status_o[7]); // R2
    AST_WARN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (tec_i >= WV || rec_i >= WV) |=> status_o[6]); // R3
    AST_RXOK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ok_i |=> status_o[4]); // R4
    AST_TXOK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ok_i |=> status_o[3]); // R5
    AST_LEC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (err_i && !frame_start_i) ##1 (err_i && !frame_start_i && !sw_wr_i)
        |=> $stable(status_o[2:0])); // R6
    AST_STAT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        stat_irq_o |-> $past(ctl_gie_i && ctl_sie_i)); // R8
    AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o |-> $past(ctl_gie_i && ctl_eie_i)); // R9

endmodule

bind busnode_status_reg bsr_checker #(
    .CNT_W   (CNT_W),
    .WARN_LIM(WARN_LIM),
    .OFF_LIM (OFF_LIM)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start_i(frame_start_i),
    .rx_ok_i      (rx_ok_i),
    .tx_ok_i      (tx_ok_i),
    .err_i        (err_i),
    .recover_i    (recover_i),
    .sw_wr_i      (sw_wr_i),
    .tec_i        (tec_i),
    .rec_i        (rec_i),
    .ctl_gie_i    (ctl_gie_i),
    .ctl_sie_i    (ctl_sie_i),
    .ctl_eie_i    (ctl_eie_i),
    .status_o     (status_o),
    .stat_irq_o   (stat_irq_o),
    .err_irq_o    (err_irq_o)
);

// File: tb/sim_busnode_status_reg.sv
module sim_busnode_status_reg;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 9;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start_i = 1'b0;
    logic             rx_ok_i = 1'b0;
    logic             tx_ok_i = 1'b0;
    logic             err_i = 1'b0;
    logic [2:0]       err_code_i = '0;
    logic [CNT_W-1:0] tec_i = '0;
    logic [CNT_W-1:0] rec_i = '0;
    logic             recover_i = 1'b0;
    logic             sw_wr_i = 1'b0;
    logic [7:0]       sw_wdata_i = '0;
    logic             ctl_gie_i = 1'b0;
    logic             ctl_sie_i = 1'b0;
    logic             ctl_eie_i = 1'b0;
    logic [7:0]       status_o;
    logic             tx_float_o;
    logic             stat_irq_o;
    logic             err_irq_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    busnode_status_reg #(.CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start_i(frame_start_i),
        .rx_ok_i(rx_ok_i), .tx_ok_i(tx_ok_i), .err_i(err_i),
        .err_code_i(err_code_i), .tec_i(tec_i), .rec_i(rec_i),
        .recover_i(recover_i), .sw_wr_i(sw_wr_i), .sw_wdata_i(sw_wdata_i),
        .ctl_gie_i(ctl_gie_i), .ctl_sie_i(ctl_sie_i), .ctl_eie_i(ctl_eie_i),
        .status_o(status_o), .tx_float_o(tx_float_o),
        .stat_irq_o(stat_irq_o), .err_irq_o(err_irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        frame_start_i = 0; rx_ok_i = 0; tx_ok_i = 0; err_i = 0;
        recover_i = 0; sw_wr_i = 0; sw_wdata_i = '0;
    endtask

    task automatic sw_write(input logic [7:0] v);
        sw_wr_i = 1; sw_wdata_i = v; step(); quiet();
    endtask

    task automatic t_reset();
        chk("R1 reset status", status_o, 8'h00);
        chk("R1 reset float", tx_float_o, 0);
        chk("R1 reset irqs", {stat_irq_o, err_irq_o}, 0);
    endtask

    task automatic t_rx();
        ctl_gie_i = 1; ctl_sie_i = 1;
        rx_ok_i = 1; step(); quiet();
        chk("R4 rx sets", status_o, 8'h10);
        chk("R8 rx request", stat_irq_o, 1);
        step();
        chk("R8 request one cycle", stat_irq_o, 0);
        chk("R4 rx sticky", status_o, 8'h10);
        sw_write(8'h00);
        chk("R7 sw clears rx", status_o, 8'h00);
    endtask

    task automatic t_tx();
        ctl_gie_i = 1; ctl_sie_i = 1;
        tx_ok_i = 1; step(); quiet();
        chk("R5 tx sets", status_o, 8'h08);
        chk("R8 tx request", stat_irq_o, 1);
        sw_write(8'h00);
        ctl_gie_i = 0;
        tx_ok_i = 1; step(); quiet();
        chk("R10 tx sets with gie low", status_o, 8'h08);
        chk("R10 no request", stat_irq_o, 0);
        sw_write(8'h00);
        ctl_gie_i = 1;
    endtask

    task automatic t_lec();
        ctl_gie_i = 1; ctl_sie_i = 1;
        frame_start_i = 1; err_i = 1; err_code_i = 3'd1; step(); quiet();
        chk("R6 first error stuff", status_o[2:0], 3'd1);
        chk("R8 lec change request", stat_irq_o, 1);
        err_i = 1; err_code_i = 3'd6; step(); quiet();
        chk("R6 second error ignored", status_o[2:0], 3'd1);
        chk("R8 no request on ignored error", stat_irq_o, 0);
        frame_start_i = 1; step(); quiet();
        chk("R6 rearm keeps code", status_o[2:0], 3'd1);
        err_i = 1; err_code_i = 3'd6; step(); quiet();
        chk("R6 new frame crc", status_o[2:0], 3'd6);
        chk("R8 request crc", stat_irq_o, 1);
        frame_start_i = 1; step(); quiet();
        err_i = 1; err_code_i = 3'd6; step(); quiet();
        chk("R6 same code", status_o[2:0], 3'd6);
        chk("R8 no request same code", stat_irq_o, 0);
    endtask

    task automatic t_sw();
        sw_write(8'hFF);
        chk("R7 write loads low bits only", status_o, 8'h1F);
        chk("R7 write raises no request", stat_irq_o, 0);
        sw_wr_i = 1; sw_wdata_i = 8'h00; rx_ok_i = 1; step(); quiet();
        chk("R7 hardware wins", status_o, 8'h10);
        sw_write(8'h00);
        chk("R7 cleared", status_o, 8'h00);
    endtask

    task automatic t_warn();
        ctl_gie_i = 1; ctl_eie_i = 1;
        rec_i = 9'd95; step();
        chk("R3 below limit", status_o[6], 0);
        chk("R9 no request below", err_irq_o, 0);
        rec_i = 9'd96; step();
        chk("R3 at limit", status_o[6], 1);
        chk("R9 warn request", err_irq_o, 1);
        step();
        chk("R9 request once", err_irq_o, 0);
        chk("R3 warn held", status_o[6], 1);
        rec_i = 9'd10; step();
        chk("R3 warn clears", status_o[6], 0);
        ctl_eie_i = 0;
        tec_i = 9'd120; step();
        chk("R3 tec warn", status_o[6], 1);
        chk("R9 gated by eie", err_irq_o, 0);
        tec_i = 9'd0; rec_i = 9'd0; step();
    endtask

    task automatic t_busoff();
        ctl_gie_i = 1; ctl_eie_i = 1;
        tec_i = 9'd256; step();
        chk("R2 busoff sets", status_o[7:6], 2'b11);
        chk("R2 float", tx_float_o, 1);
        chk("R9 busoff request", err_irq_o, 1);
        tec_i = 9'd0; step();
        chk("R2 busoff held", status_o[7:6], 2'b10);
        chk("R2 float held", tx_float_o, 1);
        recover_i = 1; step(); quiet();
        chk("R2 recovery clears", status_o[7], 0);
        chk("R2 float released", tx_float_o, 0);
        rec_i = 9'd300; recover_i = 1; step(); quiet();
        chk("R2 recovery wins", status_o[7], 0);
        rec_i = 9'd0; step();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        step();
        t_reset();
        t_rx();
        t_tx();
        t_lec();
        t_sw();
        t_warn();
        t_busoff();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule